// File: doc/BRIEF.md
# Multiplexed Parallel Bus Burst Target

This block answers transactions on a shared, synchronous bus where one 32-bit path carries an address in the first clock and data words in every later clock. It owns a 16-word register window at a fixed base address. An initiator opens a transaction by asserting the active-low transaction strobe, and the block claims addresses inside its window. It then reads or writes consecutive words for as long as the initiator keeps the burst open.

No length is ever sent. The block starts at the word named by the address and moves one word on each clock where both ready strobes are low. It stops when the initiator raises the transaction strobe on the final word. When the burst runs into the top of the window, the block forces a disconnect instead. Read bursts get one turnaround clock before the block drives data. The block generates even parity one clock behind every word it drives and checks parity one clock behind every word it accepts.

Every bus line that the block drives has its own output and output-enable pins, so board-level or pad logic can build the shared wires.

Top module: `pbt_target`

## Requirements
- R1: After reset, the claim, target-ready and stop strobes are high, all output enables are low and the parity-fault strobe is high.
- R2: The address phase is a clock where the transaction strobe is low after being high in the previous clock. The block claims the transaction, driving the claim strobe low from the next clock, only when address bits [31:6] match the base (0x0000_1000) and the command is a read (0x6, 0xC, 0xE) or a write (0x7, 0xF). Any other transaction is never claimed and leaves memory untouched.
- R3: On a write, target-ready goes low together with claim, one clock after the address phase. Every clock with both ready strobes low stores the bus word, writing byte k only when command/byte-enable bit k is low.
- R4: On a read, target-ready first goes low two clocks after the address phase. The data output enable rises in that same clock and stays low during the turnaround clock.
- R5: Each burst starts at word index address[5:2] and increments by one after each transfer. A read transfer presents the current word. All three read codes behave identically.
- R6: A transfer that occurs while the transaction strobe is high ends the burst. In the next clock, claim, ready and stop are high and the data enable is low.
- R7: When the current index is 15 and target-ready is low, the stop strobe is also low. If that transfer happens with the transaction strobe still low, the next clock has ready high with claim and stop held low until the transaction strobe is seen high.
- R8: In the clock after every clock with the data enable high, the parity enable is high and the parity output equals the XOR of the data output and command/byte-enable bits of that earlier clock. Otherwise the parity enable is low.
- R9: For a write transfer in clock T, the parity input in clock T+1 is compared with the XOR of that word and its byte enables. On a mismatch, the fault strobe is low in clock T+2, and it is high in every other clock.
- R10: A clock in which initiator-ready is high moves no word, leaves the index unchanged and keeps target-ready low.
- R11: The control output enable is high in every clock with claim low and in the one clock after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ad_i | input | 32 | Address/data lines as received |
| bus_ad_o | output | 32 | Read data to drive onto the address/data lines |
| bus_ad_oe_o | output | 1 | Enable for bus_ad_o |
| cmd_be_n_i | input | 4 | Command in the address phase, active-low byte enables afterwards |
| txn_active_n_i | input | 1 | Initiator's active-low transaction strobe |
| init_ready_n_i | input | 1 | Initiator ready, active low |
| tgt_ready_n_o | output | 1 | Target ready, active low |
| claim_n_o | output | 1 | Target claims the transaction, active low |
| halt_n_o | output | 1 | Target requests a disconnect, active low |
| ctl_oe_o | output | 1 | Enable for claim, ready and stop outputs |
| parity_i | input | 1 | Even parity from the initiator, one clock late |
| parity_o | output | 1 | Even parity over driven data and byte enables, one clock late |
| parity_oe_o | output | 1 | Enable for parity_o |
| parity_fault_n_o | output | 1 | Write-data parity mismatch, active low |

## Verification
A wrong burst index shows up at the data port on the very next read transfer as a word from the wrong location. For writes, it shows up later as wrong data in a read-back, or as the stop strobe appearing at the wrong word. A state machine stuck in the wrong state shows within one clock: claim or ready held low after a final transfer, a missing turnaround clock, or stop failing to release once the initiator ends the burst. Parity pipeline slips appear as a parity mismatch or a misplaced fault pulse exactly one or two clocks after the word concerned.

// File: rtl/pbt_pkg.sv
`timescale 1ns/1ps
package pbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD_TURN,
    ST_RD,
    ST_DISC
  } tgt_state_e;

  localparam logic [3:0] CMD_RD      = 4'h6;
  localparam logic [3:0] CMD_RD_LINE = 4'hE;
  localparam logic [3:0] CMD_RD_MULT = 4'hC;
  localparam logic [3:0] CMD_WR      = 4'h7;
  localparam logic [3:0] CMD_WR_INV  = 4'hF;
endpackage

// File: rtl/pbt_decode.sv
`timescale 1ns/1ps
module pbt_decode import pbt_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        cmd_i,
  output logic              hit_o,
  output logic              read_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int LOW = IDX_W + 2;

  logic is_rd, is_wr, in_win;

  always_comb begin
    is_rd  = (cmd_i == CMD_RD) || (cmd_i == CMD_RD_LINE) || (cmd_i == CMD_RD_MULT);
    is_wr  = (cmd_i == CMD_WR) || (cmd_i == CMD_WR_INV);
    in_win = (addr_i[ADDR_W-1:LOW] == BASE_ADDR[ADDR_W-1:LOW]);
    hit_o  = in_win && (is_rd || is_wr);
    read_o = is_rd;
    idx_o  = addr_i[LOW-1:2];
  end
endmodule

// File: rtl/pbt_word_store.sv
`timescale 1ns/1ps
module pbt_word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (we_i && wbe_i[g]) lane_mem[widx_i] <= wdata_i[8*g +: 8];
      lane_q <= lane_mem[ridx_i];
    end

    assign rdata_o[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/pbt_parity.sv
`timescale 1ns/1ps
module pbt_parity #(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] drv_data_i,
  input  logic              drv_oe_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              chk_en_i,
  input  logic              parity_i,
  output logic              parity_o,
  output logic              parity_oe_o,
  output logic              fault_n_o
);
  logic chk_q, exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      parity_o    <= 1'b0;
      parity_oe_o <= 1'b0;
      chk_q       <= 1'b0;
      exp_q       <= 1'b0;
      fault_n_o   <= 1'b1;
    end else begin
      parity_o    <= ^{drv_data_i, be_i};
      parity_oe_o <= drv_oe_i;
      chk_q       <= chk_en_i;
      exp_q       <= ^{rx_data_i, be_i};
      fault_n_o   <= !(chk_q && (parity_i != exp_q));
    end
  end
endmodule

// File: rtl/pbt_target.sv
`timescale 1ns/1ps
module pbt_target import pbt_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter logic [DATA_W-1:0] BASE_ADDR = 'h1000,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe_o,
  input  logic [BE_W-1:0]   cmd_be_n_i,
  input  logic              txn_active_n_i,
  input  logic              init_ready_n_i,
  output logic              tgt_ready_n_o,
  output logic              claim_n_o,
  output logic              halt_n_o,
  output logic              ctl_oe_o,
  input  logic              parity_i,
  output logic              parity_o,
  output logic              parity_oe_o,
  output logic              parity_fault_n_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  tgt_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, dec_idx, rd_idx;
  logic             frame_q, dec_hit, dec_read, start, xfer, in_data_d, wr_en;

  pbt_decode #(.ADDR_W(DATA_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr_i (bus_ad_i),
    .cmd_i  (cmd_be_n_i[3:0]),
    .hit_o  (dec_hit),
    .read_o (dec_read),
    .idx_o  (dec_idx)
  );

  // Address phase: strobe low now, high in the previous clock.
  assign start = (state_q == ST_IDLE) && !txn_active_n_i && frame_q;
  assign xfer  = ((state_q == ST_WR) || (state_q == ST_RD)) && !init_ready_n_i;
  assign wr_en = xfer && (state_q == ST_WR);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (start && dec_hit) begin
        idx_d   = dec_idx;
        state_d = dec_read ? ST_RD_TURN : ST_WR;
      end
      ST_RD_TURN: state_d = ST_RD;
      ST_WR, ST_RD: if (xfer) begin
        if (txn_active_n_i)        state_d = ST_IDLE;
        else if (idx_q == LAST_IDX) state_d = ST_DISC;
        else                       idx_d   = idx_q + 1'b1;
      end
      ST_DISC: if (txn_active_n_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign in_data_d = (state_d == ST_WR) || (state_d == ST_RD);

  // Read port address runs one word ahead on a read transfer so the
  // registered memory output is ready for the next data clock.
  always_comb begin
    if (state_q == ST_IDLE) rd_idx = dec_idx;
    else if (xfer)          rd_idx = idx_q + 1'b1;
    else                    rd_idx = idx_q;
  end

  pbt_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .we_i    (wr_en),
    .widx_i  (idx_q),
    .wdata_i (bus_ad_i),
    .wbe_i   (~cmd_be_n_i),
    .ridx_i  (rd_idx),
    .rdata_o (bus_ad_o)
  );

  pbt_parity #(.DATA_W(DATA_W)) u_parity (
    .clk         (clk),
    .rst         (rst),
    .drv_data_i  (bus_ad_o),
    .drv_oe_i    (bus_ad_oe_o),
    .be_i        (cmd_be_n_i),
    .rx_data_i   (bus_ad_i),
    .chk_en_i    (wr_en),
    .parity_i    (parity_i),
    .parity_o    (parity_o),
    .parity_oe_o (parity_oe_o),
    .fault_n_o   (parity_fault_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      idx_q         <= '0;
      frame_q       <= 1'b1;
      claim_n_o     <= 1'b1;
      tgt_ready_n_o <= 1'b1;
      halt_n_o      <= 1'b1;
      bus_ad_oe_o   <= 1'b0;
      ctl_oe_o      <= 1'b0;
    end else begin
      state_q       <= state_d;
      idx_q         <= idx_d;
      frame_q       <= txn_active_n_i;
      claim_n_o     <= (state_d == ST_IDLE);
      tgt_ready_n_o <= !in_data_d;
      halt_n_o      <= !((in_data_d && (idx_d == LAST_IDX)) || (state_d == ST_DISC));
      bus_ad_oe_o   <= (state_d == ST_RD);
      ctl_oe_o      <= (state_d != ST_IDLE) || (state_q != ST_IDLE);
    end
  end
endmodule

// File: rtl/pbt_checker.sv
`timescale 1ns/1ps
module pbt_checker #(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_ad_o,
  input logic              bus_ad_oe_o,
  input logic [BE_W-1:0]   cmd_be_n_i,
  input logic              txn_active_n_i,
  input logic              init_ready_n_i,
  input logic              tgt_ready_n_o,
  input logic              claim_n_o,
  input logic              halt_n_o,
  input logic              ctl_oe_o,
  input logic              parity_o,
  input logic              parity_oe_o,
  input logic              parity_fault_n_o
);
  assert_claim_after_addr_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(claim_n_o) |-> (!$past(txn_active_n_i) && $past(txn_active_n_i, 2)));

  assert_ready_claimed_R3: assert property (@(posedge clk) disable iff (rst)
    !tgt_ready_n_o |-> !claim_n_o);

  assert_turnaround_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(claim_n_o) && tgt_ready_n_o) |-> !bus_ad_oe_o);

  assert_drive_with_ready_R4: assert property (@(posedge clk) disable iff (rst)
    bus_ad_oe_o |-> !tgt_ready_n_o);

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (!tgt_ready_n_o && !init_ready_n_i && txn_active_n_i) |=> (claim_n_o && tgt_ready_n_o && halt_n_o));

  assert_stop_claimed_R7: assert property (@(posedge clk) disable iff (rst)
    !halt_n_o |-> !claim_n_o);

  assert_par_en_on_R8: assert property (@(posedge clk) disable iff (rst)
    bus_ad_oe_o |=> parity_oe_o);

  assert_par_en_off_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_ad_oe_o |=> !parity_oe_o);

  assert_par_value_R8: assert property (@(posedge clk) disable iff (rst)
    bus_ad_oe_o |=> (parity_o == $past(^{bus_ad_o, cmd_be_n_i})));

  assert_fault_after_write_R9: assert property (@(posedge clk) disable iff (rst)
    !parity_fault_n_o |-> $past(!tgt_ready_n_o && !init_ready_n_i && !bus_ad_oe_o, 2));

  assert_wait_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!tgt_ready_n_o && init_ready_n_i) |=> !tgt_ready_n_o);

  assert_ctl_enable_R11: assert property (@(posedge clk) disable iff (rst)
    !claim_n_o |-> ctl_oe_o);

  assert_ctl_tail_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(claim_n_o) |-> ctl_oe_o);
endmodule

bind pbt_target pbt_checker #(.DATA_W(DATA_W)) i_pbt_checker (
  .clk              (clk),
  .rst              (rst),
  .bus_ad_o         (bus_ad_o),
  .bus_ad_oe_o      (bus_ad_oe_o),
  .cmd_be_n_i       (cmd_be_n_i),
  .txn_active_n_i   (txn_active_n_i),
  .init_ready_n_i   (init_ready_n_i),
  .tgt_ready_n_o    (tgt_ready_n_o),
  .claim_n_o        (claim_n_o),
  .halt_n_o         (halt_n_o),
  .ctl_oe_o         (ctl_oe_o),
  .parity_o         (parity_o),
  .parity_oe_o      (parity_oe_o),
  .parity_fault_n_o (parity_fault_n_o)
);

// File: tb/test_pbt_target.sv
`timescale 1ns/1ps
module test_pbt_target;
  localparam int DEPTH = 16;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_ad_i = '0;
  logic [31:0] bus_ad_o;
  logic        bus_ad_oe_o;
  logic [3:0]  cmd_be_n_i = 4'hF;
  logic        txn_active_n_i = 1'b1;
  logic        init_ready_n_i = 1'b1;
  logic        tgt_ready_n_o, claim_n_o, halt_n_o, ctl_oe_o;
  logic        parity_i = 1'b0;
  logic        parity_o, parity_oe_o, parity_fault_n_o;

  always #4 clk = ~clk;

  pbt_target i_pbt_target (
    .clk(clk), .rst(rst), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o), .bus_ad_oe_o(bus_ad_oe_o),
    .cmd_be_n_i(cmd_be_n_i), .txn_active_n_i(txn_active_n_i), .init_ready_n_i(init_ready_n_i),
    .tgt_ready_n_o(tgt_ready_n_o), .claim_n_o(claim_n_o), .halt_n_o(halt_n_o), .ctl_oe_o(ctl_oe_o),
    .parity_i(parity_i), .parity_o(parity_o), .parity_oe_o(parity_oe_o),
    .parity_fault_n_o(parity_fault_n_o)
  );

  int          n_chk = 0, n_fail = 0, faults_seen = 0;
  bit          finished = 0;
  bit          wx1 = 0, wx2 = 0, cor1 = 0, inj_req = 0, prev_oe = 0, prev_claim = 0;
  logic [35:0] prev_bits = '0;
  logic [31:0] ref_mem [DEPTH];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit even_par(input logic [31:0] d, input logic [3:0] b);
    return ^{d, b};
  endfunction

  // One bus clock: check outputs at the falling edge, then drive inputs.
  task automatic tick(input logic fr, input logic ir, input logic [31:0] a, input logic [3:0] c,
                      input bit e_claim, input bit e_rdy, input bit e_stop, input bit e_oe,
                      input bit wr_txn, input string tg);
    bit corrupt, e_fault;
    @(negedge clk);
    chk(claim_n_o === !e_claim, tg, "claim", 32'(claim_n_o), 32'(!e_claim));
    chk(tgt_ready_n_o === !e_rdy, tg, "ready", 32'(tgt_ready_n_o), 32'(!e_rdy));
    chk(halt_n_o === !e_stop, "R7", "stop", 32'(halt_n_o), 32'(!e_stop));
    chk(bus_ad_oe_o === e_oe, "R4", "data enable", 32'(bus_ad_oe_o), 32'(e_oe));
    chk(ctl_oe_o === (e_claim || prev_claim), "R11", "ctl enable", 32'(ctl_oe_o),
        32'(e_claim || prev_claim));
    e_fault = wx2 && cor1;
    if (e_fault) faults_seen++;
    chk(parity_fault_n_o === !e_fault, "R9", "parity fault", 32'(parity_fault_n_o), 32'(!e_fault));
    chk(parity_oe_o === prev_oe, "R8", "parity enable", 32'(parity_oe_o), 32'(prev_oe));
    if (prev_oe)
      chk(parity_o === ^prev_bits, "R8", "parity value", 32'(parity_o), 32'(^prev_bits));
    corrupt = inj_req && wx1;
    if (corrupt) inj_req = 0;
    parity_i = even_par(bus_ad_i, cmd_be_n_i) ^ corrupt;
    wx2 = wx1;
    cor1 = corrupt;
    prev_oe = bus_ad_oe_o;
    prev_bits = {bus_ad_o, c};
    prev_claim = e_claim;
    txn_active_n_i = fr;
    init_ready_n_i = ir;
    bus_ad_i = a;
    cmd_be_n_i = c;
    wx1 = wr_txn && e_rdy && !ir;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b1, 32'h0, 4'hF, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic run_txn(input bit wr, input logic [3:0] cmd, input int start, input int n,
                         input int wpct, input bit full_be);
    int idx, c, moved, guard, exp_moved;
    bit fr_off, done, disc, had_wait, ir, fr, e_rdy, e_stop;
    logic [31:0] d;
    logic [3:0] be;
    idx = start; c = 1; moved = 0; guard = 0;
    fr_off = 0; done = 0; disc = 0; had_wait = 0;
    tick(1'b0, 1'b1, BASE + 32'(start * 4), cmd, 0, 0, 0, 0, 0, "R2");
    while (!done) begin
      ir = fr_off ? 1'b0 : (($urandom % 100) < 32'(wpct));
      if (ir && c >= 2) had_wait = 1;
      fr = fr_off || ((moved == n - 1) && !ir);
      if (fr) fr_off = 1;
      d  = wr ? $urandom : 32'h0;
      be = wr ? (full_be ? 4'h0 : 4'($urandom)) : 4'h0;
      e_rdy  = wr ? 1'b1 : (c >= 2);
      e_stop = e_rdy && (idx == DEPTH - 1);
      tick(fr, ir, d, be, 1, e_rdy, e_stop, !wr && c >= 2, wr, wr ? "R3" : "R4");
      if (e_rdy && !ir) begin
        if (!wr)
          chk(bus_ad_o === ref_mem[idx], had_wait ? "R10" : "R5", "read word",
              bus_ad_o, ref_mem[idx]);
        else
          for (int k = 0; k < 4; k++)
            if (!be[k]) ref_mem[idx][8*k +: 8] = d[8*k +: 8];
        moved++;
        if (fr) done = 1;
        else if (idx == DEPTH - 1) begin done = 1; disc = 1; end
        else idx++;
      end
      c++;
      guard++;
      if (guard > 300) begin
        chk(0, "R6", "burst never ended", 32'(moved), 32'(n));
        done = 1;
      end
    end
    if (disc) tick(1'b1, 1'b1, 32'h0, 4'hF, 1, 0, 1, 0, wr, "R7");
    tick(1'b1, 1'b1, 32'h0, 4'hF, 0, 0, 0, 0, 0, "R6");
    exp_moved = (n < DEPTH - start) ? n : DEPTH - start;
    chk(moved == exp_moved, "R7", "words moved", 32'(moved), 32'(exp_moved));
  endtask

  task automatic run_miss(input logic [3:0] cmd, input logic [31:0] addr, input int n);
    tick(1'b0, 1'b1, addr, cmd, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < n; i++)
      tick(i == n - 1, 1'b0, $urandom, 4'($urandom), 0, 0, 0, 0, 0, "R2");
    tick(1'b1, 1'b1, 32'h0, 4'hF, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [3:0] rd_cmds [3];
    void'($urandom(32'd2024));
    rd_cmds[0] = 4'h6; rd_cmds[1] = 4'hE; rd_cmds[2] = 4'hC;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(claim_n_o === 1'b1 && tgt_ready_n_o === 1'b1 && halt_n_o === 1'b1, "R1", "strobes",
        {29'h0, claim_n_o, tgt_ready_n_o, halt_n_o}, 32'h7);
    chk(bus_ad_oe_o === 1'b0 && parity_oe_o === 1'b0 && ctl_oe_o === 1'b0, "R1", "enables",
        {29'h0, bus_ad_oe_o, parity_oe_o, ctl_oe_o}, 32'h0);
    chk(parity_fault_n_o === 1'b1, "R1", "fault", 32'(parity_fault_n_o), 32'h1);

    // Fill the window: burst longer than the window forces a disconnect at 15 (R7).
    run_txn(1, 4'h7, 0, 20, 0, 1);
    // Read every word back with one burst; last word coincides with stop and final (R5, R6).
    run_txn(0, 4'hC, 0, 16, 0, 0);
    // Single-word read at the top of the window.
    run_txn(0, 4'h6, 15, 1, 0, 0);
    // Write with invalidate code, random byte enables, wait states (R3, R10).
    run_txn(1, 4'hF, 3, 5, 40, 0);
    run_txn(0, 4'hE, 2, 7, 40, 0);
    // Parity error on a write word (R9).
    inj_req = 1;
    run_txn(1, 4'h7, 8, 3, 0, 0);
    idle(3);
    chk(faults_seen > 0, "R9", "fault pulses seen", 32'(faults_seen), 32'h1);
    // Not claimed: outside window, and unsupported code inside window (R2).
    run_miss(4'h7, BASE + 32'h40, 4);
    run_miss(4'h3, BASE + 32'h8, 3);
    run_miss(4'h2, BASE, 2);

    for (int t = 0; t < 60; t++) begin
      int kind;
      kind = int'($urandom % 10);
      if (kind == 0) run_miss(4'h7, BASE + 32'h40 + 32'(($urandom % 8) * 4), 3);
      else if (kind == 1) run_miss(4'hB, BASE + 32'(($urandom % 16) * 4), 2);
      else begin
        bit wr;
        int st, len;
        wr  = ($urandom % 2) == 1;
        st  = int'($urandom % 16);
        len = (($urandom % 6) == 0) ? 20 : int'($urandom % 6) + 1;
        if (wr && ($urandom % 4) == 0) inj_req = 1;
        run_txn(wr, wr ? ((($urandom % 2) == 1) ? 4'h7 : 4'hF) : rd_cmds[$urandom % 3],
                st, len, 30, 0);
      end
    end
    inj_req = 0;
    idle(2);
    // Final read-back proves misses left memory untouched (R2).
    run_txn(0, 4'hE, 0, 16, 20, 0);
    idle(3);
    report();
  end
endmodule